// File: doc/BRIEF.md
# Analog Pad Handshake Responder

This block models the peripheral side of an analog game pad that a host reads over a three-wire nibble handshake. The host drives a select line (`th_i`, active low) and a toggle line (`tr_i`). The block answers with a 4-bit data nibble on `nib_o` and an acknowledge level on `tl_o`. Each time the host flips the toggle line while select is low, the block presents the next nibble of its stream. It then copies the new toggle level onto the acknowledge line, which tells the host that the nibble is valid.

The stream carries active-low button states and four 8-bit analog channels: stick X, stick Y, right trigger and left trigger. Its layout depends on a mode switch. Analog mode sends an identifier, a byte count, the four button nibbles, the eight analog nibbles and one zero terminator. Digital mode sends only the identifier, the count and the button nibbles. After the stream ends, the block returns 1 with the acknowledge line held high.

The digital trigger bits are not separate inputs. They come from the analog trigger values through a comparator with hysteresis. All inputs are captured into a snapshot while select is high, so a multi-nibble field never mixes an old half with a new half. The select and toggle lines are asynchronous to the block clock and pass through synchronizers.

Top module: `analog_pad_responder`

## Requirements
- R1: After reset `tl_o` is 1 and `nib_o` is 4'hF.
- R2: While the synchronized select is high, `tl_o` is driven to 1, `nib_o` to 4'hF, and the stream position returns to its first nibble. A transfer aborted midway restarts from the identifier.
- R3: While select is low, each change of the synchronized toggle line presents the next nibble and sets `tl_o` equal to the new toggle level. Output latency from a pin change is SYNC_STAGES+1 clocks.
- R4: In analog mode (`analog_mode_i`=1) the stream opens with nibble 1 (identifier), then 6 (byte count), then {right,left,down,up}, {start,a,c,b}, {right trigger bit,x,y,z} and {left trigger bit,1,1,1}, bit 3 first in each list.
- R5: In analog mode the button nibbles are followed by stick X high and low nibbles, then stick Y high and low, then right trigger high and low, then left trigger high and low.
- R6: In analog mode a single 4'h0 follows the left trigger low nibble. Every later toggle returns 4'h1 with `tl_o` held at 1.
- R7: In digital mode (`analog_mode_i`=0) the stream is 0, 2 and the same four button nibbles. Every later toggle returns 4'h1 with `tl_o` held at 1.
- R8: A trigger digital bit becomes 0 (pressed) one clock after its analog value is above HI_THR (default 8'h90).
- R9: A trigger digital bit becomes 1 (released) one clock after its analog value is below LO_THR (default 8'h56). Between the two thresholds, inclusive, it keeps its previous value.
- R10: Changes to the analog values, the buttons or the mode while select is low do not affect the transfer in progress. The stream uses the values present just before select fell.
- R11: While select stays low and the toggle line does not change, `nib_o` and `tl_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| th_i | input | 1 | Host select, active low, asynchronous |
| tr_i | input | 1 | Host toggle line, asynchronous |
| analog_mode_i | input | 1 | 1 = analog stream, 0 = digital stream |
| stick_x_i | input | 8 | Stick X, 0x00 left, 0x80 centre, 0xFF right |
| stick_y_i | input | 8 | Stick Y, 0x00 top, 0x80 centre, 0xFF bottom |
| trig_r_i | input | 8 | Right trigger analog value, 0x00 released |
| trig_l_i | input | 8 | Left trigger analog value, 0x00 released |
| dir_n_i | input | 4 | {right,left,down,up}, 0 = pressed |
| key_n_i | input | 4 | {start,a,c,b}, 0 = pressed |
| face_n_i | input | 3 | {x,y,z}, 0 = pressed |
| nib_o | output | 4 | Data nibble presented to the host |
| tl_o | output | 1 | Acknowledge level |

## Verification
Some rules can be checked on every cycle. The assertions cover the idle-high forcing under select and acknowledge changes that only ever copy the toggle level. They also cover outputs that hold when no toggle arrives, the three-way trigger comparator rule and the frozen snapshot during a transfer. The exact nibble order of each mode, the terminator and end-of-stream behaviour, restart after an abort and the use of the stale snapshot are not visible cycle by cycle. Those show up only in the bench's complete transfers, where every presented nibble is compared against a stream built from the requirements.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int AXIS_W   = 8;
  localparam int NIB_W    = 4;
  localparam int IDX_W    = 4;
  localparam int ANA_TERM = 14;   // index of the zero terminator
  localparam int ANA_END  = ANA_TERM + 1;
  localparam int DIG_END  = 6;

  typedef logic [NIB_W-1:0] nib_t;

  typedef struct packed {
    logic              analog;
    logic [AXIS_W-1:0] x;
    logic [AXIS_W-1:0] y;
    logic [AXIS_W-1:0] tr;
    logic [AXIS_W-1:0] tl;
    logic [3:0]        dir_n;
    logic [3:0]        key_n;
    logic [2:0]        face_n;
    logic              trr_n;
    logic              trl_n;
  } snap_t;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '1;  // idle lines high
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pad_hyst.sv
module pad_hyst #(
  parameter int          W  = 8,
  parameter logic [W-1:0] HI = 8'h90,
  parameter logic [W-1:0] LO = 8'h56
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  output logic         bit_n_o
);
  logic pressed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pressed_q <= 1'b0;
    else if (val_i > HI)  pressed_q <= 1'b1;
    else if (val_i < LO)  pressed_q <= 1'b0;
  end

  assign bit_n_o = ~pressed_q;
endmodule

// File: rtl/pad_seq.sv
module pad_seq
  import pad_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  th_i,
  input  logic  tr_i,
  input  snap_t snap_i,
  output nib_t  nib_o,
  output logic  tl_o
);
  logic [IDX_W-1:0] idx_q;
  logic             tl_q;
  nib_t             nib_q;
  logic             step;
  logic             past_end;
  logic [IDX_W-1:0] end_idx;
  nib_t             nib_next;

  function automatic nib_t pick(input logic [IDX_W-1:0] i, input snap_t s);
    nib_t n;
    case (i)
      4'd0:    n = s.analog ? 4'h1 : 4'h0;
      4'd1:    n = s.analog ? 4'h6 : 4'h2;
      4'd2:    n = s.dir_n;
      4'd3:    n = s.key_n;
      4'd4:    n = {s.trr_n, s.face_n};
      4'd5:    n = {s.trl_n, 3'b111};
      4'd6:    n = s.x[7:4];
      4'd7:    n = s.x[3:0];
      4'd8:    n = s.y[7:4];
      4'd9:    n = s.y[3:0];
      4'd10:   n = s.tr[7:4];
      4'd11:   n = s.tr[3:0];
      4'd12:   n = s.tl[7:4];
      4'd13:   n = s.tl[3:0];
      4'd14:   n = 4'h0;
      default: n = 4'h1;
    endcase
    return n;
  endfunction

  assign end_idx  = snap_i.analog ? IDX_W'(ANA_END) : IDX_W'(DIG_END);
  assign past_end = (idx_q >= end_idx);
  assign step     = !th_i && (tr_i != tl_q);
  assign nib_next = past_end ? 4'h1 : pick(idx_q, snap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      tl_q  <= 1'b1;
      nib_q <= 4'hF;
    end else if (th_i) begin
      idx_q <= '0;
      tl_q  <= 1'b1;
      nib_q <= 4'hF;
    end else if (step) begin
      nib_q <= nib_next;
      tl_q  <= past_end ? 1'b1 : tr_i;
      if (!past_end) idx_q <= idx_q + 1'b1;
    end
  end

  assign nib_o = nib_q;
  assign tl_o  = tl_q;
endmodule

// File: rtl/analog_pad_responder.sv
module analog_pad_responder
  import pad_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [AXIS_W-1:0] HI_THR      = 8'h90,
  parameter logic [AXIS_W-1:0] LO_THR      = 8'h56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              th_i,
  input  logic              tr_i,
  input  logic              analog_mode_i,
  input  logic [AXIS_W-1:0] stick_x_i,
  input  logic [AXIS_W-1:0] stick_y_i,
  input  logic [AXIS_W-1:0] trig_r_i,
  input  logic [AXIS_W-1:0] trig_l_i,
  input  logic [3:0]        dir_n_i,
  input  logic [3:0]        key_n_i,
  input  logic [2:0]        face_n_i,
  output logic [3:0]        nib_o,
  output logic              tl_o
);
  localparam int NTRIG = 2;

  logic [1:0]        line_s;
  logic              th_s, tr_s;
  logic [AXIS_W-1:0] trig_val [NTRIG];
  logic [NTRIG-1:0]  trig_n;
  logic              trr_n, trl_n;
  snap_t             snap_d, snap_q;

  pad_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({th_i, tr_i}),
    .q_o   (line_s)
  );
  assign th_s = line_s[1];
  assign tr_s = line_s[0];

  assign trig_val[0] = trig_r_i;
  assign trig_val[1] = trig_l_i;

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    pad_hyst #(.W(AXIS_W), .HI(HI_THR), .LO(LO_THR)) u_hyst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .val_i  (trig_val[g]),
      .bit_n_o(trig_n[g])
    );
  end
  assign trr_n = trig_n[0];
  assign trl_n = trig_n[1];

  always_comb begin
    snap_d.analog = analog_mode_i;
    snap_d.x      = stick_x_i;
    snap_d.y      = stick_y_i;
    snap_d.tr     = trig_r_i;
    snap_d.tl     = trig_l_i;
    snap_d.dir_n  = dir_n_i;
    snap_d.key_n  = key_n_i;
    snap_d.face_n = face_n_i;
    snap_d.trr_n  = trr_n;
    snap_d.trl_n  = trl_n;
  end

  // snapshot tracks inputs while idle, frozen for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '{analog: 1'b1, x: 8'h80, y: 8'h80, tr: '0, tl: '0,
                  dir_n: '1, key_n: '1, face_n: '1, trr_n: 1'b1, trl_n: 1'b1};
    end else if (th_s) begin
      snap_q <= snap_d;
    end
  end

  pad_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .th_i  (th_s),
    .tr_i  (tr_s),
    .snap_i(snap_q),
    .nib_o (nib_o),
    .tl_o  (tl_o)
  );
endmodule

// File: rtl/pad_chk.sv
module pad_chk
  import pad_pkg::*;
#(
  parameter logic [AXIS_W-1:0] HI = 8'h90,
  parameter logic [AXIS_W-1:0] LO = 8'h56
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              th_s,
  input logic              tr_s,
  input logic [3:0]        nib_o,
  input logic              tl_o,
  input logic [AXIS_W-1:0] trig_r_i,
  input logic [AXIS_W-1:0] trig_l_i,
  input logic              trr_n,
  input logic              trl_n,
  input snap_t             snap_q
);
  a_r2_idle_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    th_s |=> (tl_o && nib_o == 4'hF));

  a_r3_ack_copies_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(th_s) && !$stable(tl_o)) |-> (tl_o == $past(tr_s)));

  a_r11_hold_no_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!th_s && tr_s == tl_o) |=> ($stable(nib_o) && $stable(tl_o)));

  a_r8_right_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_r_i > HI) |=> !trr_n);

  a_r8_left_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_l_i > HI) |=> !trl_n);

  a_r9_right_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_r_i < LO) |=> trr_n);

  a_r9_left_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_l_i < LO) |=> trl_n);

  a_r9_left_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_l_i >= LO && trig_l_i <= HI) |=> (trl_n == $past(trl_n)));

  a_r10_snapshot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !th_s |=> $stable(snap_q));
endmodule

bind analog_pad_responder pad_chk #(.HI(HI_THR), .LO(LO_THR)) u_pad_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .th_s    (th_s),
  .tr_s    (tr_s),
  .nib_o   (nib_o),
  .tl_o    (tl_o),
  .trig_r_i(trig_r_i),
  .trig_l_i(trig_l_i),
  .trr_n   (trr_n),
  .trl_n   (trl_n),
  .snap_q  (snap_q)
);

// File: tb/tb_analog_pad_responder.sv
module tb_analog_pad_responder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       th_i = 1'b1, tr_i = 1'b1, analog_mode_i = 1'b1;
  logic [7:0] stick_x_i = 8'h80, stick_y_i = 8'h80, trig_r_i = 8'h00, trig_l_i = 8'h00;
  logic [3:0] dir_n_i = 4'hF, key_n_i = 4'hF;
  logic [2:0] face_n_i = 3'h7;
  logic [3:0] nib_o;
  logic       tl_o;

  int n_chk = 0, n_bad = 0;
  // bench-side model of trigger digital bits and captured stream values
  logic       m_r_n = 1'b1, m_l_n = 1'b1;
  logic       e_mode;
  logic [7:0] e_x, e_y, e_r, e_l;
  logic [3:0] e_dir, e_key;
  logic [2:0] e_face;
  logic       e_rn, e_ln;

  always #10 clk_i = ~clk_i;

  analog_pad_responder dut (.*);

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_trig(input logic [7:0] r, input logic [7:0] l);
    trig_r_i = r; trig_l_i = l;
    if (r > 8'h90) m_r_n = 1'b0; else if (r < 8'h56) m_r_n = 1'b1;
    if (l > 8'h90) m_l_n = 1'b0; else if (l < 8'h56) m_l_n = 1'b1;
    wait_cyc(3);
  endtask

  function automatic logic [3:0] exp_nib(input int k);
    int last;
    last = e_mode ? 14 : 5;
    if (k > last) return 4'h1;
    case (k)
      0:  return e_mode ? 4'h1 : 4'h0;
      1:  return e_mode ? 4'h6 : 4'h2;
      2:  return e_dir;
      3:  return e_key;
      4:  return {e_rn, e_face};
      5:  return {e_ln, 3'b111};
      6:  return e_x[7:4];
      7:  return e_x[3:0];
      8:  return e_y[7:4];
      9:  return e_y[3:0];
      10: return e_r[7:4];
      11: return e_r[3:0];
      12: return e_l[7:4];
      13: return e_l[3:0];
      default: return 4'h0;
    endcase
  endfunction

  // full transfer of n nibbles; chg_at >= 0 alters inputs after that step
  task automatic run_stream(input string req, input int n, input int chg_at);
    int last;
    th_i = 1'b1; tr_i = 1'b1;
    wait_cyc(6);
    e_mode = analog_mode_i; e_x = stick_x_i; e_y = stick_y_i;
    e_r = trig_r_i; e_l = trig_l_i; e_dir = dir_n_i; e_key = key_n_i;
    e_face = face_n_i; e_rn = m_r_n; e_ln = m_l_n;
    last = e_mode ? 14 : 5;
    for (int k = 0; k < n; k++) begin
      if (k == 0) begin th_i = 1'b0; tr_i = 1'b0; end
      else tr_i = k[0];
      wait_cyc(5);
      chk($sformatf("%s nib%0d", req, k), {4'h0, nib_o}, {4'h0, exp_nib(k)});
      chk($sformatf("%s ack%0d", req, k), {7'h0, tl_o},
          {7'h0, (k > last) ? 1'b1 : k[0]});
      if (k == chg_at) begin
        stick_x_i = ~stick_x_i; analog_mode_i = ~analog_mode_i;
        key_n_i = 4'h0; trig_l_i = 8'hFF;
        wait_cyc(3);
      end
    end
    th_i = 1'b1; tr_i = 1'b1;
    wait_cyc(6);
  endtask

  task automatic t_reset;
    chk("R1 reset tl", {7'h0, tl_o}, 8'h01);
    chk("R1 reset nib", {4'h0, nib_o}, 8'h0F);
  endtask

  task automatic t_analog_idle;  // R4 R5 R6 R3
    analog_mode_i = 1'b1;
    run_stream("R4/R5/R6 idle", 17, -1);
  endtask

  task automatic t_analog_vals;  // R4 R5
    stick_x_i = 8'h00; stick_y_i = 8'hFF; dir_n_i = 4'b1010; key_n_i = 4'b0110;
    face_n_i = 3'b101;
    set_trig(8'hC3, 8'h3A);
    run_stream("R5 values", 16, -1);
  endtask

  task automatic t_digital;  // R7
    analog_mode_i = 1'b0; dir_n_i = 4'b0111; key_n_i = 4'b1110;
    run_stream("R7 digital", 9, -1);
    analog_mode_i = 1'b1;
  endtask

  task automatic t_hyst;  // R8 R9
    set_trig(8'h00, 8'h91);
    run_stream("R8 press", 6, -1);
    set_trig(8'h56, 8'h70);
    run_stream("R9 band", 6, -1);
    set_trig(8'h90, 8'h55);
    run_stream("R9 release", 6, -1);
    set_trig(8'h91, 8'h90);
    run_stream("R8 edge", 6, -1);
  endtask

  task automatic t_snapshot;  // R10
    stick_x_i = 8'h5C; analog_mode_i = 1'b1; key_n_i = 4'hF;
    set_trig(8'h00, 8'h00);
    run_stream("R10 frozen", 16, 2);
    analog_mode_i = 1'b1;
    set_trig(8'h00, 8'h00);
  endtask

  task automatic t_abort;  // R2
    th_i = 1'b1; tr_i = 1'b1; wait_cyc(6);
    th_i = 1'b0; tr_i = 1'b0; wait_cyc(5);
    tr_i = 1'b1; wait_cyc(5);
    chk("R2 mid nib", {4'h0, nib_o}, 8'h06);
    th_i = 1'b1; wait_cyc(5);
    chk("R2 abort tl", {7'h0, tl_o}, 8'h01);
    chk("R2 abort nib", {4'h0, nib_o}, 8'h0F);
    tr_i = 1'b0; th_i = 1'b0; wait_cyc(5);
    chk("R2 restart id", {4'h0, nib_o}, 8'h01);
    chk("R2 restart ack", {7'h0, tl_o}, 8'h00);
    th_i = 1'b1; tr_i = 1'b1; wait_cyc(6);
  endtask

  task automatic t_hold;  // R11
    th_i = 1'b0; tr_i = 1'b0; wait_cyc(5);
    tr_i = 1'b1; wait_cyc(5);
    wait_cyc(30);
    chk("R11 hold nib", {4'h0, nib_o}, 8'h06);
    chk("R11 hold tl", {7'h0, tl_o}, 8'h01);
    th_i = 1'b1; wait_cyc(6);
  endtask

  initial begin
    wait_cyc(3);
    t_reset;
    rst_ni = 1'b1;
    wait_cyc(3);
    t_analog_idle;
    t_analog_vals;
    t_digital;
    t_hyst;
    t_snapshot;
    t_abort;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule